// File: doc/BRIEF.md
# Byte-Lane Write-Enable Synchronous RAM

A single-port, single-clock memory holding words of two independent byte lanes. Each lane has its own write-enable bit. On every rising edge where the global enable is high, each lane either stores its byte of the write word at the addressed location or loads its output byte with the byte already stored there. It never does both in the same cycle.

A lane that is being written keeps its previous output byte. It shows neither the old stored value nor the new one. Read data is always registered and comes from the clock edge, with no combinational path from the array to the outputs. A synchronous reset clears the output register but leaves the stored contents alone. The depth is a parameter, and the address width is derived from it.

Top module: `lane_ram`

## Requirements
- R1: After a synchronous active-high reset, rdData is 16'h0000. Reset does not alter stored memory contents.
- R2: While en is low, no stored byte and no output byte changes, whatever the other inputs are.
- R3: With en high and laneWe[0] set, wrData[7:0] is stored into lane 0 at addr. Lane 1 is unaffected unless laneWe[1] is also set.
- R4: With en high and laneWe[1] set, wrData[15:8] is stored into lane 1 at addr. Lane 0 is unaffected unless laneWe[0] is also set.
- R5: With en high and laneWe[i] clear, rdData byte i equals the byte of lane i stored at addr before that edge. It is valid one cycle after the edge.
- R6: On an edge where lane i is written, rdData byte i keeps its prior value.
- R7: Mixed cycles follow the per-lane rules independently. One lane may write while the other reads the same address.
- R8: Depth is parameter DEPTH (default 256). The address width is clog2(DEPTH), and every address from 0 to DEPTH-1 is usable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| en | input | 1 | Global access enable |
| laneWe | input | 2 | Write enable per byte lane; bit 0 is the low byte |
| addr | input | clog2(DEPTH) | Word address |
| wrData | input | 16 | Write word |
| rdData | output | 16 | Registered read word |

## Verification
Both write and read take effect at the same enabled rising edge. A stored byte becomes visible through a read issued on a later edge. rdData settles right after the edge that loaded it, so the bench drives inputs on the falling edge and samples rdData on the next falling edge, which is half a cycle after the responsible rising edge. A reference model in the bench holds the memory image and the expected output register and is updated once per enabled edge. Every sample is compared against it, so reads after writes, held bytes and disabled cycles are all due exactly one sample later.

// File: rtl/lane_ram_pkg.sv
package lane_ram_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;

  typedef struct packed {
    logic [LANES-1:0] wrStb;
    logic [LANES-1:0] rdStb;
    logic             clrOut;
  } laneCtl_t;
endpackage

// File: rtl/lane_ram_ctrl.sv
module lane_ram_ctrl
  import lane_ram_pkg::*;
(
  input  logic             rst,
  input  logic             en,
  input  logic [LANES-1:0] laneWe,
  output laneCtl_t         ctl
);
  always_comb begin
    ctl.clrOut = rst;
    for (int i = 0; i < LANES; i++) begin
      ctl.wrStb[i] = en & laneWe[i];
      ctl.rdStb[i] = en & ~laneWe[i] & ~rst;
    end
  end
endmodule

// File: rtl/lane_ram_dp.sv
module lane_ram_dp
  import lane_ram_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
  input  logic                    clk,
  input  laneCtl_t                ctl,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wrData,
  output logic [LANES*LANE_W-1:0] rdData
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] outByte;

    always_ff @(posedge clk) begin
      if (ctl.wrStb[g])
        bank[addr] <= wrData[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (ctl.clrOut)
        outByte <= '0;
      else if (ctl.rdStb[g])
        outByte <= bank[addr];
    end

    assign rdData[g*LANE_W +: LANE_W] = outByte;
  end
endmodule

// File: rtl/lane_ram.sv
module lane_ram
  import lane_ram_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [1:0]    laneWe,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wrData,
  output logic [15:0]   rdData
);
  laneCtl_t ctl;

  lane_ram_ctrl u_ctrl (
    .rst(rst), .en(en), .laneWe(laneWe), .ctl(ctl)
  );

  lane_ram_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .ctl(ctl), .addr(addr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/lane_ram_chk.sv
module lane_ram_chk #(
  parameter int AW = 8
)(
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [1:0]    laneWe,
  input logic [AW-1:0] addr,
  input logic [15:0]   rdData
);
  logic seen;
  always_ff @(posedge clk) seen <= 1'b1;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> rdData == 16'h0);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (seen && !en) |=> $stable(rdData));

  p_lane0_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (seen && en && laneWe[0]) |=> rdData[7:0] == $past(rdData[7:0]));

  p_lane1_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (seen && en && laneWe[1]) |=> rdData[15:8] == $past(rdData[15:8]));

  p_known_out_r5: assert property (@(posedge clk) disable iff (rst)
    seen |-> !$isunknown(laneWe) || !en);
endmodule

bind lane_ram lane_ram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .laneWe(laneWe), .addr(addr), .rdData(rdData)
);

// File: tb/test_lane_ram.sv
module test_lane_ram;
  localparam int DEPTH = 256;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst = 1, en = 0;
  logic [1:0] laneWe = 0;
  logic [AW-1:0] addr = 0;
  logic [15:0] wrData = 0;
  logic [15:0] rdData;

  int checks = 0, errors = 0;
  logic [15:0] mem [DEPTH];
  logic [15:0] expOut = 0;

  always #4 clk = ~clk;

  lane_ram #(.DEPTH(DEPTH)) i_lane_ram (.*);

  function automatic logic [15:0] nextOut(logic [15:0] cur, logic [15:0] stored,
                                          logic [1:0] we);
    logic [15:0] r = cur;
    if (!we[0]) r[7:0]  = stored[7:0];
    if (!we[1]) r[15:8] = stored[15:8];
    return r;
  endfunction

  function automatic logic [15:0] nextMem(logic [15:0] cur, logic [15:0] d,
                                          logic [1:0] we);
    logic [15:0] r = cur;
    if (we[0]) r[7:0]  = d[7:0];
    if (we[1]) r[15:8] = d[15:8];
    return r;
  endfunction

  task automatic check(string req, logic [15:0] exp);
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s rdData=%h expected=%h", req, rdData, exp);
    end
  endtask

  // drive at negedge, one rising edge, sample at next negedge
  task automatic cyc(logic e, logic [1:0] we, logic [AW-1:0] a, logic [15:0] d,
                     string req);
    en = e; laneWe = we; addr = a; wrData = d;
    @(negedge clk);
    if (e) begin
      expOut = nextOut(expOut, mem[a], we);
      mem[a] = nextMem(mem[a], d, we);
    end
    check(req, expOut);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog rdData=%h expected=done", rdData);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    @(negedge clk); @(negedge clk);
    rst = 0;
    expOut = 0;
    check("R1", 16'h0000);
    // fill full memory, both lanes (R3, R4, R8)
    for (int i = 0; i < DEPTH; i++) cyc(1, 2'b11, i[AW-1:0], 16'hA500 ^ 16'(i*3), "R3");
    // read back boundaries (R5, R8)
    cyc(1, 2'b00, 0, 16'hFFFF, "R5");
    cyc(1, 2'b00, AW'(DEPTH-1), 16'hFFFF, "R8");
    check("R8", 16'hA500 ^ 16'((DEPTH-1)*3));
    // write holds output (R6)
    cyc(1, 2'b11, 5, 16'h1234, "R6");
    cyc(1, 2'b00, 5, 0, "R4");
    check("R3", 16'h1234);
    // mixed same address (R7)
    cyc(1, 2'b01, 5, 16'hEEAA, "R7");
    check("R7", 16'h1234);
    cyc(1, 2'b10, 5, 16'h77BB, "R7");
    check("R7", 16'h12AA);
    cyc(1, 2'b00, 5, 0, "R7");
    check("R7", 16'h77AA);
    // disabled cycles (R2)
    cyc(0, 2'b11, 5, 16'hDEAD, "R2");
    cyc(0, 2'b00, 9, 16'hDEAD, "R2");
    cyc(1, 2'b00, 5, 0, "R2");
    check("R2", 16'h77AA);
    // reset clears output, not memory (R1)
    rst = 1; en = 1; laneWe = 0; addr = 9;
    @(negedge clk);
    rst = 0; expOut = 0;
    check("R1", 16'h0000);
    cyc(1, 2'b00, 5, 0, "R1");
    check("R1", 16'h77AA);
    // random mix
    for (int k = 0; k < 3000; k++)
      cyc($urandom_range(0, 3) != 0, 2'($urandom), AW'($urandom), 16'($urandom), "R7");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule